// File: doc/BRIEF.md
# Receive Data-Path Protocol Guard

This block sits behind the word decoder of a 16-bit packet receive interface. Every clock it takes one word together with a control/data qualifier. It follows the receive data path through four conditions: idle, just after a payload control word, inside a data burst, and inside a training pattern. It raises a one-cycle error pulse for each of four kinds of violation: an illegal transition, SOP control words placed too close together, data with no opening payload control word, and a burst that stops on a bad length without an end of packet.

The block also repairs the stream. Stray data is dropped until a payload control word opens a burst. A burst that breaks the length rule is closed internally as an aborted end of packet. Bursts that continue a packet closed this way are discarded until a new packet starts.

The cleaned output is a registered stream of data words. Each word carries its channel address and SOP, EOP and error marks. The block holds back one word so that the word ending a packet can carry its EOP mark.

Top module: `rx_proto_guard`

## Requirements
- R1: Word decoding. With `in_ctl`=1 and bit 15 set, the word is a payload control word: bits 14:13 give the end status of the previous burst (00 none, 01 abort, 10 end with two bytes, 11 end with one byte), bit 12 is SOP, bits 11:4 the channel and bits 3:0 parity, which is ignored. With `in_ctl`=1, the value 16'h0FFF is a training control word and any other word with bit 15 clear is idle, whose bits 14:13 hold the same end status. With `in_ctl`=0 the word is data.
- R2: After reset every output is low. The first SOP control word never raises a spacing error.
- R3: `err_proto` is high for one cycle, in the cycle after the word, when any of these holds: a control word carries a non-zero end status while no data burst is in progress; a control word directly follows a payload control word; a training control word directly follows a data word.
- R4: `err_sop_gap` is high for one cycle when an SOP payload control word comes fewer than 8 cycles after the previous one. A gap of exactly 8 raises nothing. The data stream is unaffected.
- R5: `err_no_sob` is high for one cycle when a data word arrives in the idle condition. Further data words in the same dropping run raise no further pulse.
- R6: Data words that arrive after a start-of-burst error never reach the output until a payload control word arrives.
- R7: `err_boundary` is high for one cycle when a control word without end status ends a burst whose data-word count is not a multiple of 8.
- R8: On a boundary error, the last held word of the burst leaves with `out_eop` and `out_err` both set, and the packet is closed.
- R9: While no packet is open, a payload control word without SOP opens a burst whose data is discarded silently, with no output.
- R10: Each accepted data word leaves the block one accepted word later, or in the cycle after the control word that ends its burst. `out_sop` marks the first word after an SOP control word. `out_chan` carries that burst's channel. `out_eop` marks the last word when the closing control word has a non-zero end status, and `out_err` is added when that status is 01.
- R11: Data words after a training control word are taken as training data. They raise no error and are not output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_ctl | input | 1 | 1: the word is a control word |
| in_word | input | 16 | Incoming word |
| out_valid | output | 1 | Output word valid |
| out_data | output | 16 | Output data word |
| out_sop | output | 1 | First word of a packet |
| out_eop | output | 1 | Last word of a packet |
| out_err | output | 1 | Packet aborted or errored |
| out_chan | output | 8 | Channel of the output word |
| err_proto | output | 1 | Illegal transition pulse |
| err_sop_gap | output | 1 | SOP spacing violation pulse |
| err_no_sob | output | 1 | Data without payload control pulse |
| err_boundary | output | 1 | Burst length violation pulse |

## Verification
The stream is driven with several patterns:
- Clean single-burst and multi-burst packets, which fix the one-word hold-back, SOP placement and channel tagging.
- Idle-ended aborts, which separate the abort mark from a normal end.
- SOP pairs 4 and exactly 8 cycles apart, which find the edge of the spacing rule.
- A five-word burst closed by idle, which shows the internal abort and the silent discard of the orphan burst that follows.
- Stray data, training patterns and back-to-back control words, which keep the three protocol-error causes apart from the start-of-burst error.

A behavioural model in the bench predicts every output on every clock.

// File: rtl/rxg_pkg.sv
package rxg_pkg;

    localparam int WORD_W = 16;
    localparam int CHAN_W = 8;
    localparam logic [WORD_W-1:0] TRAIN_CTL_WORD = 16'h0FFF;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PCW,
        ST_DATA,
        ST_TRAIN,
        ST_DROP
    } path_st_e;

    typedef enum logic [1:0] {
        EOS_NONE  = 2'b00,
        EOS_ABORT = 2'b01,
        EOS_TWO   = 2'b10,
        EOS_ONE   = 2'b11
    } eop_stat_e;

    typedef struct packed {
        logic              is_data;
        logic              is_pay;
        logic              is_trc;
        logic              sop;
        eop_stat_e         eos;
        logic [CHAN_W-1:0] chan;
    } word_info_t;

    typedef struct packed {
        logic              valid;
        logic              sop;
        logic              eop;
        logic              err;
        logic [CHAN_W-1:0] chan;
        logic [WORD_W-1:0] data;
    } out_beat_t;

    function automatic word_info_t classify(input logic ctl, input logic [WORD_W-1:0] w);
        word_info_t r;
        r.is_data = !ctl;
        r.is_pay  = ctl && w[15];
        r.is_trc  = ctl && (w == TRAIN_CTL_WORD);
        r.sop     = ctl && w[15] && w[12];
        r.eos     = ctl ? eop_stat_e'(w[14:13]) : EOS_NONE;
        r.chan    = w[11:4];
        return r;
    endfunction

endpackage

// File: rtl/rxg_decode.sv
module rxg_decode
    import rxg_pkg::*;
(
    input  logic              ctl,
    input  logic [WORD_W-1:0] word,
    output word_info_t        info
);
    always_comb info = classify(ctl, word);
endmodule

// File: rtl/rxg_sop_gap.sv
module rxg_sop_gap #(
    parameter int MIN_GAP = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic sop_seen,
    output logic gap_err
);
    localparam int CW = $clog2(MIN_GAP + 1);
    localparam logic [CW-1:0] SAT = CW'(MIN_GAP);

    logic [CW-1:0] since;

    always_ff @(posedge clk) begin
        if (rst) begin
            since   <= SAT;
            gap_err <= 1'b0;
        end else begin
            gap_err <= sop_seen && (since < SAT);
            if (sop_seen)
                since <= CW'(1);
            else if (since < SAT)
                since <= since + CW'(1);
        end
    end
endmodule

// File: rtl/rxg_path_fsm.sv
module rxg_path_fsm
    import rxg_pkg::*;
#(
    parameter int BURST_WORDS = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  word_info_t        info,
    output logic              err_proto,
    output logic              err_sob,
    output logic              err_bnd,
    output logic              acc,
    output logic              acc_sop,
    output logic [CHAN_W-1:0] acc_chan,
    output logic              fl,
    output logic              fl_eop,
    output logic              fl_err
);
    localparam int CNT_W = (BURST_WORDS > 1) ? $clog2(BURST_WORDS) : 1;

    path_st_e          st;
    logic [CNT_W-1:0]  cnt;
    logic              pkt_open;
    logic              burst_ok;
    logic              sop_pend;
    logic [CHAN_W-1:0] chan_q;

    logic ctl, in_burst, proto_n, sob_n, bnd_n, close_n;

    always_comb begin
        ctl      = !info.is_data;
        in_burst = (st == ST_DATA);
        proto_n  = ctl && (((info.eos != EOS_NONE) && !in_burst) ||
                           (st == ST_PCW) ||
                           (info.is_trc && in_burst));
        bnd_n    = ctl && in_burst && (info.eos == EOS_NONE) && (cnt != '0);
        close_n  = ctl && in_burst && ((info.eos != EOS_NONE) || bnd_n);
        sob_n    = info.is_data && (st == ST_IDLE);
        acc      = info.is_data && ((st == ST_PCW) || (st == ST_DATA)) && burst_ok;
        acc_sop  = sop_pend;
        acc_chan = chan_q;
        fl       = ctl && in_burst;
        fl_eop   = close_n;
        fl_err   = bnd_n || (info.eos == EOS_ABORT);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_IDLE;
            cnt       <= '0;
            pkt_open  <= 1'b0;
            burst_ok  <= 1'b0;
            sop_pend  <= 1'b0;
            chan_q    <= '0;
            err_proto <= 1'b0;
            err_sob   <= 1'b0;
            err_bnd   <= 1'b0;
        end else begin
            err_proto <= proto_n;
            err_sob   <= sob_n;
            err_bnd   <= bnd_n;
            if (info.is_data) begin
                unique case (st)
                    ST_PCW, ST_DATA: begin
                        st  <= ST_DATA;
                        cnt <= cnt + CNT_W'(1);
                        if (acc)
                            sop_pend <= 1'b0;
                    end
                    ST_IDLE: st <= ST_DROP;
                    default: st <= st;
                endcase
            end else begin
                if (close_n)
                    pkt_open <= 1'b0;
                if (info.is_pay) begin
                    st       <= ST_PCW;
                    cnt      <= '0;
                    chan_q   <= info.chan;
                    sop_pend <= info.sop;
                    if (info.sop) begin
                        pkt_open <= 1'b1;
                        burst_ok <= 1'b1;
                    end else begin
                        burst_ok <= pkt_open && !close_n;
                    end
                end else if (info.is_trc) begin
                    st <= ST_TRAIN;
                end else begin
                    st <= ST_IDLE;
                end
            end
        end
    end
endmodule

// File: rtl/rxg_out_stage.sv
module rxg_out_stage
    import rxg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              acc,
    input  logic              acc_sop,
    input  logic [CHAN_W-1:0] acc_chan,
    input  logic [WORD_W-1:0] data,
    input  logic              fl,
    input  logic              fl_eop,
    input  logic              fl_err,
    output out_beat_t         beat
);
    logic              h_v;
    logic              h_sop;
    logic [CHAN_W-1:0] h_chan;
    logic [WORD_W-1:0] h_data;
    out_beat_t         nxt;

    always_comb begin
        nxt = '0;
        if ((acc || fl) && h_v) begin
            nxt.valid = 1'b1;
            nxt.sop   = h_sop;
            nxt.chan  = h_chan;
            nxt.data  = h_data;
            nxt.eop   = fl && fl_eop;
            nxt.err   = fl && fl_err;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            beat   <= '0;
            h_v    <= 1'b0;
            h_sop  <= 1'b0;
            h_chan <= '0;
            h_data <= '0;
        end else begin
            beat <= nxt;
            if (acc) begin
                h_v    <= 1'b1;
                h_sop  <= acc_sop;
                h_chan <= acc_chan;
                h_data <= data;
            end else if (fl) begin
                h_v <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/rx_proto_guard.sv
module rx_proto_guard
    import rxg_pkg::*;
#(
    parameter int BURST_WORDS = 8,
    parameter int MIN_SOP_GAP = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        in_ctl,
    input  logic [15:0] in_word,
    output logic        out_valid,
    output logic [15:0] out_data,
    output logic        out_sop,
    output logic        out_eop,
    output logic        out_err,
    output logic [7:0]  out_chan,
    output logic        err_proto,
    output logic        err_sop_gap,
    output logic        err_no_sob,
    output logic        err_boundary
);
    word_info_t        info;
    logic              acc, acc_sop, fl, fl_eop, fl_err;
    logic [CHAN_W-1:0] acc_chan;
    out_beat_t         beat;

    rxg_decode u_dec (
        .ctl  (in_ctl),
        .word (in_word),
        .info (info)
    );

    rxg_sop_gap #(.MIN_GAP(MIN_SOP_GAP)) u_gap (
        .clk      (clk),
        .rst      (rst),
        .sop_seen (info.sop),
        .gap_err  (err_sop_gap)
    );

    rxg_path_fsm #(.BURST_WORDS(BURST_WORDS)) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .info      (info),
        .err_proto (err_proto),
        .err_sob   (err_no_sob),
        .err_bnd   (err_boundary),
        .acc       (acc),
        .acc_sop   (acc_sop),
        .acc_chan  (acc_chan),
        .fl        (fl),
        .fl_eop    (fl_eop),
        .fl_err    (fl_err)
    );

    rxg_out_stage u_out (
        .clk      (clk),
        .rst      (rst),
        .acc      (acc),
        .acc_sop  (acc_sop),
        .acc_chan (acc_chan),
        .data     (in_word),
        .fl       (fl),
        .fl_eop   (fl_eop),
        .fl_err   (fl_err),
        .beat     (beat)
    );

    assign out_valid = beat.valid;
    assign out_data  = beat.data;
    assign out_sop   = beat.sop;
    assign out_eop   = beat.eop;
    assign out_err   = beat.err;
    assign out_chan  = beat.chan;
endmodule

// File: rtl/rxg_guard_chk.sv
module rxg_guard_chk (
    input logic        clk,
    input logic        rst,
    input logic        in_ctl,
    input logic [15:0] in_word,
    input logic        out_valid,
    input logic        out_sop,
    input logic        out_eop,
    input logic        out_err,
    input logic        err_proto,
    input logic        err_sop_gap,
    input logic        err_no_sob,
    input logic        err_boundary
);
    assert_proto_ctl_R3: assert property (@(posedge clk) disable iff (rst)
        err_proto |-> $past(in_ctl));

    assert_gap_sop_R4: assert property (@(posedge clk) disable iff (rst)
        err_sop_gap |-> $past(in_ctl && in_word[15] && in_word[12]));

    assert_sob_once_R5: assert property (@(posedge clk) disable iff (rst)
        err_no_sob |=> !err_no_sob);

    assert_sob_data_R5: assert property (@(posedge clk) disable iff (rst)
        err_no_sob |-> !$past(in_ctl));

    assert_sob_quiet_R6: assert property (@(posedge clk) disable iff (rst)
        err_no_sob |-> !out_valid);

    assert_bnd_ctl_R7: assert property (@(posedge clk) disable iff (rst)
        err_boundary |-> $past(in_ctl && (in_word[14:13] == 2'b00)));

    assert_err_eop_R8: assert property (@(posedge clk) disable iff (rst)
        out_err |-> out_eop);

    assert_mark_valid_R10: assert property (@(posedge clk) disable iff (rst)
        (out_eop || out_sop) |-> out_valid);
endmodule

bind rx_proto_guard rxg_guard_chk u_chk (.*);

// File: tb/sim_rx_proto_guard.sv
`timescale 1ns/1ps
module sim_rx_proto_guard;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_ctl = 1'b1;
    logic [15:0] in_word = 16'h000F;
    logic        out_valid, out_sop, out_eop, out_err;
    logic [15:0] out_data;
    logic [7:0]  out_chan;
    logic        err_proto, err_sop_gap, err_no_sob, err_boundary;

    always #5 clk = ~clk;

    rx_proto_guard u0 (.*);

    int    checks = 0;
    int    errors = 0;
    bit    done = 1'b0;
    string cur = "R2 reset";

    // reference model state: 0 idle, 1 after payload control, 2 in burst, 3 training, 4 dropping
    int          m_st = 0;
    int          m_cnt = 0;
    int          m_gap = 8;
    bit          m_open = 1'b0;
    bit          m_ok = 1'b0;
    bit          m_spend = 1'b0;
    logic [7:0]  m_ch = 8'h00;
    logic [24:0] hq[$];

    logic        e_v, e_sop, e_eop, e_err, e_pr, e_gp, e_sb, e_bd;
    logic [7:0]  e_ch;
    logic [15:0] e_d;

    task automatic chk(input string sig, input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s during [%s]: actual %h expected %h", req, sig, cur, act, exp);
        end
    endtask

    task automatic emit(input bit eop, input bit err);
        logic [24:0] e;
        if (hq.size() != 0) begin
            e = hq.pop_front();
            e_v = 1'b1; e_sop = e[24]; e_ch = e[23:16]; e_d = e[15:0];
            e_eop = eop; e_err = err;
        end
    endtask

    task automatic model(input logic c, input logic [15:0] w);
        bit is_pay, is_trc, bnd, close;
        logic [1:0] es;
        e_v = 0; e_sop = 0; e_eop = 0; e_err = 0; e_ch = 0; e_d = 0;
        e_pr = 0; e_gp = 0; e_sb = 0; e_bd = 0;
        is_pay = c && w[15];
        is_trc = c && (w == 16'h0FFF);
        es = w[14:13];
        if (is_pay && w[12]) begin
            if (m_gap < 8) e_gp = 1;
            m_gap = 1;
        end else if (m_gap < 8) begin
            m_gap++;
        end
        if (c) begin
            if (es != 2'b00 && m_st != 2) e_pr = 1;
            if (m_st == 1) e_pr = 1;
            if (is_trc && m_st == 2) e_pr = 1;
            close = 0;
            if (m_st == 2) begin
                bnd = (es == 2'b00) && (m_cnt % 8 != 0);
                e_bd = bnd;
                close = (es != 2'b00) || bnd;
                emit(close, (es == 2'b01) || bnd);
                if (close) m_open = 0;
            end
            if (is_pay) begin
                m_st = 1; m_cnt = 0; m_ch = w[11:4];
                if (w[12]) begin m_open = 1; m_ok = 1; m_spend = 1; end
                else begin m_ok = m_open; m_spend = 0; end
            end else if (is_trc) m_st = 3;
            else m_st = 0;
        end else begin
            if (m_st == 1 || m_st == 2) begin
                m_st = 2; m_cnt++;
                if (m_ok) begin
                    emit(0, 0);
                    hq.push_back({m_spend, m_ch, w});
                    m_spend = 0;
                end
            end else if (m_st == 0) begin
                e_sb = 1; m_st = 4;
            end
        end
    endtask

    task automatic step(input logic c, input logic [15:0] w);
        in_ctl = c; in_word = w;
        @(posedge clk);
        #2;
        model(c, w);
        chk("out_valid", "R10", {15'd0, out_valid}, {15'd0, e_v});
        chk("out_sop", "R10", {15'd0, out_sop}, {15'd0, e_sop});
        chk("out_eop", "R10", {15'd0, out_eop}, {15'd0, e_eop});
        chk("out_err", "R8", {15'd0, out_err}, {15'd0, e_err});
        chk("out_chan", "R10", {8'd0, out_chan}, {8'd0, e_ch});
        chk("out_data", "R10", out_data, e_d);
        chk("err_proto", "R3", {15'd0, err_proto}, {15'd0, e_pr});
        chk("err_sop_gap", "R4", {15'd0, err_sop_gap}, {15'd0, e_gp});
        chk("err_no_sob", "R5", {15'd0, err_no_sob}, {15'd0, e_sb});
        chk("err_boundary", "R7", {15'd0, err_boundary}, {15'd0, e_bd});
        @(negedge clk);
    endtask

    function automatic logic [15:0] pay(input bit s, input logic [1:0] es, input logic [7:0] ch);
        return {1'b1, es, s, ch, 4'hA};
    endfunction

    function automatic logic [15:0] idl(input logic [1:0] es);
        return {1'b0, es, 13'h000F};
    endfunction

    task automatic dat(input int n, input logic [15:0] base);
        for (int i = 0; i < n; i++) step(1'b0, base + 16'(i));
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired during [%s]: actual hung expected finished", cur);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        cur = "R2 reset state";
        chk("out_valid", "R2", {15'd0, out_valid}, 16'd0);
        chk("out_eop", "R2", {15'd0, out_eop}, 16'd0);
        chk("err_proto", "R2", {15'd0, err_proto}, 16'd0);
        chk("err_sop_gap", "R2", {15'd0, err_sop_gap}, 16'd0);
        chk("err_no_sob", "R2", {15'd0, err_no_sob}, 16'd0);
        chk("err_boundary", "R2", {15'd0, err_boundary}, 16'd0);
        step(1'b1, idl(2'b00));
        step(1'b1, idl(2'b00));

        cur = "R1 R2 R10 single burst packet, first SOP";
        step(1'b1, pay(1, 2'b00, 8'h05));
        dat(8, 16'h1000);
        step(1'b1, idl(2'b10));
        step(1'b1, idl(2'b00));

        cur = "R10 multi-burst packet ending with one byte";
        step(1'b1, pay(1, 2'b00, 8'h03));
        dat(8, 16'h2000);
        step(1'b1, pay(0, 2'b00, 8'h03));
        dat(3, 16'h2100);
        step(1'b1, idl(2'b11));
        repeat (8) step(1'b1, idl(2'b00));

        cur = "R4 SOP gap of 4 then exactly 8";
        step(1'b1, pay(1, 2'b00, 8'h11));
        dat(2, 16'h3000);
        step(1'b1, idl(2'b10));
        step(1'b1, pay(1, 2'b00, 8'h12));
        dat(6, 16'h3100);
        step(1'b1, idl(2'b10));
        step(1'b1, pay(1, 2'b00, 8'h13));
        dat(2, 16'h3200);
        step(1'b1, idl(2'b10));

        cur = "R10 abort status closes packet";
        step(1'b1, pay(1, 2'b00, 8'h21));
        dat(4, 16'h4000);
        step(1'b1, idl(2'b01));
        step(1'b1, idl(2'b00));

        cur = "R5 R6 stray data and training data dropped";
        dat(3, 16'h5000);
        step(1'b0, 16'hF000);
        step(1'b1, idl(2'b00));
        dat(2, 16'h5100);
        step(1'b1, pay(1, 2'b00, 8'h22));
        dat(2, 16'h5200);
        step(1'b1, idl(2'b10));

        cur = "R7 R8 short burst closed by idle";
        step(1'b1, pay(1, 2'b00, 8'h09));
        dat(5, 16'h6000);
        step(1'b1, idl(2'b00));
        cur = "R9 orphan burst after closure";
        step(1'b1, pay(0, 2'b00, 8'h09));
        dat(4, 16'h6100);
        step(1'b1, idl(2'b10));
        step(1'b1, pay(0, 2'b00, 8'h09));
        dat(8, 16'h6200);
        step(1'b1, idl(2'b00));
        step(1'b1, pay(1, 2'b00, 8'h0A));
        dat(2, 16'h6300);
        step(1'b1, idl(2'b10));

        cur = "R7 boundary error ended by payload control";
        repeat (8) step(1'b1, idl(2'b00));
        step(1'b1, pay(1, 2'b00, 8'h0B));
        dat(9, 16'h6400);
        step(1'b1, pay(0, 2'b00, 8'h0B));
        dat(8, 16'h6500);
        step(1'b1, idl(2'b00));

        cur = "R3 end status without burst";
        step(1'b1, idl(2'b10));
        cur = "R3 control after payload control";
        repeat (8) step(1'b1, idl(2'b00));
        step(1'b1, pay(1, 2'b00, 8'h31));
        step(1'b1, pay(1, 2'b00, 8'h32));
        dat(2, 16'h7000);
        step(1'b1, idl(2'b10));
        cur = "R3 R11 training control right after data";
        repeat (8) step(1'b1, idl(2'b00));
        step(1'b1, pay(1, 2'b00, 8'h33));
        dat(8, 16'h7100);
        step(1'b1, 16'h0FFF);
        step(1'b0, 16'hF000);
        step(1'b0, 16'hF000);
        step(1'b1, 16'h0FFF);
        step(1'b0, 16'hF000);
        step(1'b1, idl(2'b00));
        cur = "R11 clean training pattern";
        step(1'b1, 16'h0FFF);
        step(1'b1, 16'h0FFF);
        step(1'b0, 16'hF000);
        step(1'b0, 16'hF000);
        step(1'b1, idl(2'b00));
        step(1'b1, pay(1, 2'b00, 8'h34));
        dat(8, 16'h7200);
        step(1'b1, idl(2'b10));
        step(1'b1, idl(2'b00));

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule